// File: doc/BRIEF.md
# Comma Detect and Word Aligner

This receive-side block accepts an unaligned serial stream delivered as one 20-bit word per clock. Each word holds two 10-bit symbols, and `rx_word[19]` is the earliest bit on the line. The block searches every bit position for a 10-bit comma in either running-disparity form. Both forms can be set through parameters. When it finds a comma, it moves the symbol boundary so that the comma starts on a symbol edge, and from then on it emits words cut at that boundary.

Each polarity of comma has its own enable, and only an enabled polarity may move the boundary. A range control sets where a comma may land. In the narrow range it may land in either symbol. In the wide range it always lands in the upper symbol. The block also provides the following:

- a per-symbol comma flag;
- a comma-seen indication held for several cycles, so that a slower fabric clock can capture it;
- a one-cycle realign pulse;
- an optional inversion of every incoming bit, applied ahead of all detection.

Top module: `comma_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, `sym_out`, `comma_flags`, `comma_seen` and `realign` are all zero after that edge, and the boundary offset returns to 0.
- R2: A plus-form comma (default `0011111010`, first bit on the left) moves the boundary only if `plus_align_en` was high in the cycle the comma completed its window. Otherwise the boundary, and so `sym_out`, is unchanged.
- R3: A minus-form comma (default `1100000101`) moves the boundary only if `minus_align_en` was high in that cycle.
- R4: With `wide_align` low, a comma that starts p bits after the start of the previous word is aligned at offset p mod 10. It then appears in either the upper or the lower symbol.
- R5: With `wide_align` high, the offset becomes p, so the comma always appears in `sym_out[19:10]`.
- R6: `realign` is high for exactly the cycle whose `sym_out` first uses a changed boundary. A comma found at the offset already in use gives no pulse.
- R7: `comma_seen` rises in the cycle after a comma of either form is found, whether or not it is enabled. It stays high for HOLD cycles, and a new detection restarts the count.
- R8: With `rx_invert` high, every incoming bit is complemented before detection and before output.
- R9: When more than one enabled comma starts within the same search window, the one at the lowest bit offset sets the boundary.
- R10: `comma_flags[1]` is high when `sym_out[19:10]` equals either comma form. `comma_flags[0]` is high when `sym_out[9:0]` does.
- R11: `sym_out` after the edge that takes word n equals the 20 stream bits that start at the first bit of word n-1 plus the current offset. The earliest of those bits is in bit 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 20 | Unaligned received bits, bit 19 earliest |
| rx_invert | input | 1 | Complement all incoming bits |
| plus_align_en | input | 1 | Allow realignment on plus-form comma |
| minus_align_en | input | 1 | Allow realignment on minus-form comma |
| wide_align | input | 1 | 1: comma forced to upper symbol; 0: either symbol |
| sym_out | output | 20 | Aligned word, two symbols |
| comma_flags | output | 2 | Per-symbol comma present, bit 1 upper |
| comma_seen | output | 1 | Stretched comma-detected indication |
| realign | output | 1 | One-cycle pulse on boundary change |

## Verification
The hardest situation to reach from the ports is a comma that straddles two input words, together with a second comma in the same or a later window that competes with it or confirms it. To reach it, the bench builds a bit stream of alternating filler. It places one or two commas at every bit position across two words and cuts the stream into input words. This sweeps all 20 window offsets in both range modes and both polarities. Added passes disable the matching enable, invert the line, place two commas in one window, and repeat a comma at the same or a different alignment.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int CA_SYM_W = 10;
  localparam logic [CA_SYM_W-1:0] CA_PLUS_DEF  = 10'b0011111010;
  localparam logic [CA_SYM_W-1:0] CA_MINUS_DEF = 10'b1100000101;
endpackage

// File: rtl/ca_comma_search.sv
module ca_comma_search #(
  parameter int SYM_W = 10,
  parameter int WORD_W = 20,
  parameter logic [SYM_W-1:0] PLUS_PAT = '0,
  parameter logic [SYM_W-1:0] MINUS_PAT = '0,
  localparam int WIN_W = 2 * WORD_W,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic [WIN_W-1:0] win,
  input  logic             plus_en,
  input  logic             minus_en,
  output logic             hit,
  output logic [OFF_W-1:0] pos,
  output logic             any_hit
);
  logic [WORD_W-1:0] is_plus, is_minus, usable;

  for (genvar gp = 0; gp < WORD_W; gp++) begin : g_pos
    assign is_plus[gp]  = (win[WIN_W-1-gp -: SYM_W] == PLUS_PAT);
    assign is_minus[gp] = (win[WIN_W-1-gp -: SYM_W] == MINUS_PAT);
    assign usable[gp]   = (plus_en & is_plus[gp]) | (minus_en & is_minus[gp]);
  end

  assign any_hit = |(is_plus | is_minus);

  // lowest offset wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (usable[i]) begin
        hit = 1'b1;
        pos = OFF_W'(i);
      end
    end
  end
endmodule

// File: rtl/ca_boundary.sv
module ca_boundary #(
  parameter int SYM_W = 10,
  parameter int WORD_W = 20,
  localparam int WIN_W = 2 * WORD_W,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_W-1:0]  win,
  input  logic              hit,
  input  logic [OFF_W-1:0]  pos,
  input  logic              wide,
  output logic [WORD_W-1:0] aligned_c,
  output logic [WORD_W-1:0] word_q,
  output logic              realign_q
);
  logic [OFF_W-1:0] off_q, target, next_off;
  logic [WIN_W-1:0] shifted;

  assign target   = wide ? pos : OFF_W'(pos % OFF_W'(SYM_W));
  assign next_off = hit ? target : off_q;
  assign shifted  = win << next_off;
  assign aligned_c = shifted[WIN_W-1 -: WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q     <= '0;
      word_q    <= '0;
      realign_q <= 1'b0;
    end else begin
      off_q     <= next_off;
      word_q    <= aligned_c;
      realign_q <= hit && (target != off_q);
    end
  end

  assert_narrow_span_R4: assert property (@(posedge clk) disable iff (rst)
    (realign_q && !$past(wide)) |-> (off_q < OFF_W'(SYM_W)));

  assert_pulse_on_change_R6: assert property (@(posedge clk) disable iff (rst)
    realign_q |-> (off_q != $past(off_q)));
endmodule

// File: rtl/ca_flags.sv
module ca_flags #(
  parameter int SYM_W = 10,
  parameter int NSYM = 2,
  parameter logic [SYM_W-1:0] PLUS_PAT = '0,
  parameter logic [SYM_W-1:0] MINUS_PAT = '0,
  localparam int WORD_W = SYM_W * NSYM
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] aligned_c,
  output logic [NSYM-1:0]   flags_q
);
  logic [NSYM-1:0] flags_c;

  for (genvar g = 0; g < NSYM; g++) begin : g_sym
    logic [SYM_W-1:0] sym;
    assign sym = aligned_c[(g+1)*SYM_W-1 -: SYM_W];
    assign flags_c[g] = (sym == PLUS_PAT) || (sym == MINUS_PAT);
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_c;
  end
endmodule

// File: rtl/ca_stretch.sv
module ca_stretch #(
  parameter int HOLD = 3,
  localparam int CNT_W = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse,
  output logic held
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (pulse)       cnt <= CNT_W'(HOLD);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign held = (cnt != '0);

  if (HOLD > 1) begin : g_hold_chk
    assert_hold_min_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(held) |=> held);
  end
endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import ca_pkg::*;
#(
  parameter int SYM_W = CA_SYM_W,
  parameter int NSYM = 2,
  parameter int HOLD = 3,
  parameter logic [SYM_W-1:0] PLUS_PAT = CA_PLUS_DEF,
  parameter logic [SYM_W-1:0] MINUS_PAT = CA_MINUS_DEF,
  localparam int WORD_W = SYM_W * NSYM,
  localparam int WIN_W = 2 * WORD_W,
  localparam int OFF_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_invert,
  input  logic              plus_align_en,
  input  logic              minus_align_en,
  input  logic              wide_align,
  output logic [WORD_W-1:0] sym_out,
  output logic [NSYM-1:0]   comma_flags,
  output logic              comma_seen,
  output logic              realign
);
  logic [WORD_W-1:0] cur, prev_q, aligned_c;
  logic [WIN_W-1:0]  win;
  logic              hit, any_hit;
  logic [OFF_W-1:0]  pos;

  assign cur = rx_word ^ {WORD_W{rx_invert}};
  assign win = {prev_q, cur};

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur;
  end

  ca_comma_search #(.SYM_W(SYM_W), .WORD_W(WORD_W),
                    .PLUS_PAT(PLUS_PAT), .MINUS_PAT(MINUS_PAT)) u_search (
    .win(win), .plus_en(plus_align_en), .minus_en(minus_align_en),
    .hit(hit), .pos(pos), .any_hit(any_hit));

  ca_boundary #(.SYM_W(SYM_W), .WORD_W(WORD_W)) u_bound (
    .clk(clk), .rst(rst), .win(win), .hit(hit), .pos(pos), .wide(wide_align),
    .aligned_c(aligned_c), .word_q(sym_out), .realign_q(realign));

  ca_flags #(.SYM_W(SYM_W), .NSYM(NSYM),
             .PLUS_PAT(PLUS_PAT), .MINUS_PAT(MINUS_PAT)) u_flags (
    .clk(clk), .rst(rst), .aligned_c(aligned_c), .flags_q(comma_flags));

  ca_stretch #(.HOLD(HOLD)) u_stretch (
    .clk(clk), .rst(rst), .pulse(any_hit), .held(comma_seen));

  assert_realign_gated_R2: assert property (@(posedge clk) disable iff (rst)
    realign |-> $past(plus_align_en || minus_align_en));

  assert_realign_lands_R10: assert property (@(posedge clk) disable iff (rst)
    realign |-> (comma_flags != '0));

  assert_wide_upper_R5: assert property (@(posedge clk) disable iff (rst)
    (realign && $past(wide_align)) |-> comma_flags[NSYM-1]);

  assert_realign_seen_R7: assert property (@(posedge clk) disable iff (rst)
    realign |-> comma_seen);
endmodule

// File: tb/sim_comma_aligner.sv
module sim_comma_aligner;
  localparam int HOLD = 3;
  localparam int NW = 8;
  localparam logic [9:0] PPAT = 10'b0011111010;
  localparam logic [9:0] MPAT = 10'b1100000101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [19:0] rx_word = '0;
  logic rx_invert = 1'b0, plus_align_en = 1'b0, minus_align_en = 1'b0, wide_align = 1'b0;
  logic [19:0] sym_out;
  logic [1:0]  comma_flags;
  logic        comma_seen, realign;

  int checks = 0;
  int errors = 0;
  logic [0:NW*20-1] strm;

  always #10 clk = ~clk;

  comma_aligner #(.HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .rx_word(rx_word), .rx_invert(rx_invert),
    .plus_align_en(plus_align_en), .minus_align_en(minus_align_en),
    .wide_align(wide_align), .sym_out(sym_out), .comma_flags(comma_flags),
    .comma_seen(comma_seen), .realign(realign));

  task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] slice(input int start);
    logic [19:0] w;
    for (int b = 0; b < 20; b++) w[19-b] = strm[start+b];
    return w;
  endfunction

  // q1 < 0 means a single comma
  task automatic run(input int q0, input int q1, input bit pol, input bit wide,
                     input bit enp, input bit enm, input bit inv, input string tag);
    logic [9:0] pat;
    int k, last_det, kn, best;
    bit en_ok, det;
    logic [19:0] ew;
    pat = pol ? MPAT : PPAT;
    for (int i = 0; i < NW*20; i++) strm[i] = i[0];
    for (int b = 0; b < 10; b++) strm[q0+b] = pat[9-b];
    if (q1 >= 0) for (int b = 0; b < 10; b++) strm[q1+b] = pat[9-b];
    en_ok = pol ? enm : enp;
    rst = 1'b1; rx_word = '0;
    rx_invert = inv; plus_align_en = enp; minus_align_en = enm; wide_align = wide;
    repeat (2) @(posedge clk);
    #1;
    check(sym_out == '0 && comma_flags == '0 && !comma_seen && !realign, "R1 reset", {sym_out[17:0], comma_flags}, '0);
    @(negedge clk);
    rst = 1'b0;
    k = 0; last_det = -100;
    for (int n = 0; n < NW; n++) begin
      rx_word = slice(20*n) ^ {20{inv}};
      @(posedge clk);
      #1;
      if (n >= 1) begin
        best = 99; det = 0;
        if (q0 / 20 == n - 1) begin det = 1; best = q0 % 20; end
        if (q1 >= 0 && q1 / 20 == n - 1) begin det = 1; if (q1 % 20 < best) best = q1 % 20; end
        if (det) last_det = n;
        kn = k;
        if (det && en_ok) kn = wide ? best : best % 10;
        check(realign == (kn != k), tag, {19'd0, realign}, {19'd0, kn != k});
        k = kn;
        ew = slice(20*(n-1) + k);
        check(sym_out == ew, {tag, " R11"}, sym_out, ew);
        check(comma_flags == {(ew[19:10] == PPAT || ew[19:10] == MPAT), (ew[9:0] == PPAT || ew[9:0] == MPAT)},
              "R10 flags", {18'd0, comma_flags},
              {18'd0, (ew[19:10] == PPAT || ew[19:10] == MPAT), (ew[9:0] == PPAT || ew[9:0] == MPAT)});
        check(comma_seen == (n - last_det < HOLD), "R7 seen", {19'd0, comma_seen}, {19'd0, n - last_det < HOLD});
      end
      @(negedge clk);
    end
  endtask

  initial begin
    // R4/R5/R11: every start position across two words, both forms, both ranges
    for (int w = 0; w < 2; w++)
      for (int pl = 0; pl < 2; pl++)
        for (int q = 20; q < 60; q++)
          run(q, -1, pl[0], w[0], 1'b1, 1'b1, 1'b0, w[0] ? "R5" : "R4");
    // R2: plus comma with its enable low, and with only its own enable high
    for (int q = 20; q < 60; q += 3) begin
      run(q, -1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
      run(q, -1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
    end
    // R3: minus comma with its enable low, and with only its own enable high
    for (int q = 20; q < 60; q += 3) begin
      run(q, -1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
      run(q, -1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
    end
    // R8: inverted line
    for (int q = 20; q < 60; q += 7) begin
      run(q, -1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
      run(q, -1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    end
    // R6: repeat at same alignment (no pulse) and at a new alignment (pulse again)
    for (int q = 21; q < 60; q += 9) begin
      run(q, q + 40, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
      run(q, q + 30, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
      run(q, q + 45, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
      run(q, q + 45, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
    end
    // R9: two commas in one window, lowest offset wins
    run(21, 33, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    run(21, 33, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    run(22, 36, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
    run(43, 55, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule